// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a 32-bit digital input word and raises a level-sensitive interrupt when the chosen inputs meet an edge or level condition. Only channels 4 to 19 can take part. The block first brings the inputs into the clock domain through a synchroniser. It then compares each new synchronised sample with the one before it, and combines the per-channel results in one of two global ways. In edge mode, the interrupt fires as soon as any selected channel shows its chosen edge. In level mode, it fires only when every selected channel sits at its chosen level at the same time. After a level-mode interrupt, a selected input must move before the block can fire again.

Software talks to the block through a small word-addressed register port. It reads the synchronised input word. It writes two per-channel selection masks, one for rising/high and one for falling/low, and a control word. It reads a status word that holds the channel 19:4 input state captured at the latest event, and reading it empties it. To acknowledge an interrupt, software writes the control word with the enable bit low and then writes the original value back.

Top module: `cosi_ctrl`

## Requirements
- R1: After reset, `irq` is low and every register reads as zero, the data register included while `din` is zero.
- R2: A read of byte address 0x00 returns the input word after a two-flop synchroniser. A read issued in the cycle after `din` changes still returns the old word, and the next read returns the new one.
- R3: The rise/high mask at 0x04 and the fall/low mask at 0x08 keep only bits 19:4 of a write. All other bits read back as 0.
- R4: In the control word at 0x10, bit 2 is enable and bit 1 selects the combining mode (1 = level/AND, 0 = edge/OR). No other bit is stored.
- R5: In edge mode, a rising edge on a channel set in the rise mask, or a falling edge on a channel set in the fall mask, raises `irq`. `irq` is high at the third rising clock edge after `din` changes and low before it.
- R6: In level mode, `irq` rises only when every selected channel is at its level at once: high for rise-mask bits, low for fall-mask bits. A partial match never fires.
- R7: After a level-mode interrupt, the acknowledge sequence does not re-arm the logic, and neither does a change on an unselected channel. Only a level change on a selected channel, or a write to either mask register, re-arms it.
- R8: Channels 0 to 3 and 20 to 31 never cause an interrupt and never appear in the status word.
- R9: A read of 0x0C returns the channel 19:4 state captured at the latest event, with all other bits 0. The read resets the status to 0, except when an event lands in the same cycle, in which case the new capture is kept.
- R10: `irq` stays high until the control word is written with bit 2 low, and that write drops it at the following clock edge. Events that arrive while `irq` is pending keep it high and refresh the status capture. A status read does not lower `irq`.
- R11: While bit 2 of the control word is 0, no input pattern raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Asynchronous digital inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; accesses whose bits 1:0 are not zero are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes that are never both high, and that each `din` value is held long enough for the synchroniser to settle. The stimulus respects both. It drives every register access as one isolated cycle at a falling clock edge, and it holds each input pattern for at least four cycles before the next. The channel sweeps move one input bit at a time against a quiet background, so every expected interrupt and status capture follows directly from the bit position.

// File: rtl/cosi_pkg.sv
package cosi_pkg;

  // word indices of the register map (byte address = index * 4)
  localparam int unsigned WORD_DATA      = 0;
  localparam int unsigned WORD_RISE_HIGH = 1;
  localparam int unsigned WORD_FALL_LOW  = 2;
  localparam int unsigned WORD_STATUS    = 3;
  localparam int unsigned WORD_CTRL      = 4;

  // control word bit positions
  localparam int unsigned CTRL_EN_BIT  = 2;
  localparam int unsigned CTRL_AND_BIT = 1;

  // mask with ones on channels lo..hi
  function automatic logic [63:0] chan_mask(input int unsigned lo, input int unsigned hi);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/cosi_sync.sv
module cosi_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/cosi_match.sv
module cosi_match #(
  parameter int W  = 32,
  parameter int LO = 4,
  parameter int HI = 19
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prv,
  input  logic [W-1:0] rise_hi,
  input  logic [W-1:0] fall_lo,
  output logic         edge_hit,
  output logic         level_all,
  output logic         sel_moved
);

  logic [W-1:0] edge_v;
  logic [W-1:0] meet_v;
  logic [W-1:0] sel_v;
  logic [W-1:0] move_v;

  for (genvar c = 0; c < W; c++) begin : g_chan
    localparam bit LIVE = (c >= LO) && (c <= HI);
    logic sel_c;
    assign sel_c     = LIVE & (rise_hi[c] | fall_lo[c]);
    assign sel_v[c]  = sel_c;
    assign edge_v[c] = LIVE & ((rise_hi[c] & cur[c] & ~prv[c]) |
                               (fall_lo[c] & ~cur[c] & prv[c]));
    assign meet_v[c] = ~sel_c | (rise_hi[c] & cur[c]) | (fall_lo[c] & ~cur[c]);
    assign move_v[c] = sel_c & (cur[c] ^ prv[c]);
  end

  assign edge_hit  = |edge_v;
  assign level_all = (|sel_v) & (&meet_v);
  assign sel_moved = |move_v;

endmodule

// File: rtl/cosi_regfile.sv
module cosi_regfile
  import cosi_pkg::*;
#(
  parameter int          W      = 32,
  parameter int          ADDR_W = 5,
  parameter logic [W-1:0] MASK  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      sync_word,
  input  logic [W-1:0]      status_word,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      rise_hi_q,
  output logic [W-1:0]      fall_lo_q,
  output logic              ctrl_en,
  output logic              ctrl_and,
  output logic              mode_wr,
  output logic              ctrl_off_wr,
  output logic              status_rd
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_DATA = IDX_W'(WORD_DATA);
  localparam logic [IDX_W-1:0] I_RISE = IDX_W'(WORD_RISE_HIGH);
  localparam logic [IDX_W-1:0] I_FALL = IDX_W'(WORD_FALL_LOW);
  localparam logic [IDX_W-1:0] I_STAT = IDX_W'(WORD_STATUS);
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(WORD_CTRL);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr_ok;
  logic             rd_ok;
  logic [W-1:0]     rd_mux;
  logic [W-1:0]     ctrl_word;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en & aligned;
  assign rd_ok   = rd_en & aligned;

  assign mode_wr     = wr_ok & ((idx == I_RISE) | (idx == I_FALL));
  assign ctrl_off_wr = wr_ok & (idx == I_CTRL) & ~wdata[CTRL_EN_BIT];
  assign status_rd   = rd_ok & (idx == I_STAT);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]  = ctrl_en;
    ctrl_word[CTRL_AND_BIT] = ctrl_and;
  end

  always_comb begin
    unique case (idx)
      I_DATA:  rd_mux = sync_word;
      I_RISE:  rd_mux = rise_hi_q;
      I_FALL:  rd_mux = fall_lo_q;
      I_STAT:  rd_mux = status_word;
      I_CTRL:  rd_mux = ctrl_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_hi_q <= '0;
      fall_lo_q <= '0;
      ctrl_en   <= 1'b0;
      ctrl_and  <= 1'b0;
      rdata     <= '0;
    end else begin
      if (wr_ok) begin
        if (idx == I_RISE) rise_hi_q <= wdata & MASK;
        if (idx == I_FALL) fall_lo_q <= wdata & MASK;
        if (idx == I_CTRL) begin
          ctrl_en  <= wdata[CTRL_EN_BIT];
          ctrl_and <= wdata[CTRL_AND_BIT];
        end
      end
      if (rd_ok) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/cosi_core.sv
module cosi_core #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_en,
  input  logic         ctrl_and,
  input  logic         edge_hit,
  input  logic         level_all,
  input  logic         sel_moved,
  input  logic         ctrl_off_wr,
  input  logic         mode_wr,
  input  logic         status_rd,
  input  logic [W-1:0] cur,
  output logic         hit,
  output logic         irq,
  output logic [W-1:0] status_q
);

  logic pend_q;
  logic armed_q;

  assign hit = ctrl_en & (ctrl_and ? (level_all & armed_q) : edge_hit);
  assign irq = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      armed_q  <= 1'b1;
      status_q <= '0;
    end else begin
      // disable write wins over a same-cycle event
      if (ctrl_off_wr)  pend_q <= 1'b0;
      else if (hit)     pend_q <= 1'b1;

      // a fresh capture wins over the read-to-clear
      if (hit)            status_q <= cur & MASK;
      else if (status_rd) status_q <= '0;

      if (mode_wr)               armed_q <= 1'b1;
      else if (ctrl_and && hit)  armed_q <= 1'b0;
      else if (sel_moved)        armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cosi_ctrl.sv
module cosi_ctrl #(
  parameter int W           = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CH_LO       = 4,
  parameter int CH_HI       = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      din,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq
);

  localparam logic [W-1:0] MASK = W'(cosi_pkg::chan_mask(CH_LO, CH_HI));

  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] rise_hi_q;
  logic [W-1:0] fall_lo_q;
  logic [W-1:0] status_q;
  logic         ctrl_en;
  logic         ctrl_and;
  logic         mode_wr;
  logic         ctrl_off_wr;
  logic         status_rd;
  logic         edge_hit;
  logic         level_all;
  logic         sel_moved;
  logic         hit;

  cosi_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_q;
  end

  cosi_regfile #(.W(W), .ADDR_W(ADDR_W), .MASK(MASK)) i_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .sync_word   (sync_q),
    .status_word (status_q),
    .rdata       (rdata),
    .rise_hi_q   (rise_hi_q),
    .fall_lo_q   (fall_lo_q),
    .ctrl_en     (ctrl_en),
    .ctrl_and    (ctrl_and),
    .mode_wr     (mode_wr),
    .ctrl_off_wr (ctrl_off_wr),
    .status_rd   (status_rd)
  );

  cosi_match #(.W(W), .LO(CH_LO), .HI(CH_HI)) i_match (
    .cur       (sync_q),
    .prv       (prev_q),
    .rise_hi   (rise_hi_q),
    .fall_lo   (fall_lo_q),
    .edge_hit  (edge_hit),
    .level_all (level_all),
    .sel_moved (sel_moved)
  );

  cosi_core #(.W(W), .MASK(MASK)) i_core (
    .clk         (clk),
    .rst         (rst),
    .ctrl_en     (ctrl_en),
    .ctrl_and    (ctrl_and),
    .edge_hit    (edge_hit),
    .level_all   (level_all),
    .sel_moved   (sel_moved),
    .ctrl_off_wr (ctrl_off_wr),
    .mode_wr     (mode_wr),
    .status_rd   (status_rd),
    .cur         (sync_q),
    .hit         (hit),
    .irq         (irq),
    .status_q    (status_q)
  );

endmodule

// File: rtl/cosi_checker.sv
module cosi_checker #(
  parameter int W      = 32,
  parameter int ADDR_W = 5,
  parameter int CH_LO  = 4,
  parameter int CH_HI  = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wen_bit,
  input logic              irq,
  input logic              ctrl_en,
  input logic              hit,
  input logic [W-1:0]      rise_hi_q,
  input logic [W-1:0]      fall_lo_q,
  input logic [W-1:0]      status_q
);

  localparam logic [W-1:0]      MASK   = W'(cosi_pkg::chan_mask(CH_LO, CH_HI));
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(cosi_pkg::WORD_CTRL * 4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(cosi_pkg::WORD_STATUS * 4);

  logic off_wr;
  assign off_wr = wr_en && (addr == A_CTRL) && !wen_bit;

  // R10: a disable write drops the request at the next edge
  a_r10_disable_drops: assert property (@(posedge clk) disable iff (rst)
    off_wr |=> !irq);

  // R10: a pending request holds until a disable write
  a_r10_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !off_wr) |=> irq);

  // R11: nothing is pending while disabled
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |-> !irq);

  // R5: the request only rises after a detected event
  a_r5_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(hit));

  // R3: mask registers never hold bits outside the live channels
  a_r3_mode_mask: assert property (@(posedge clk) disable iff (rst)
    ((rise_hi_q & ~MASK) == '0) && ((fall_lo_q & ~MASK) == '0));

  // R8: status never shows channels outside the live range
  a_r8_status_range: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~MASK) == '0);

  // R9: a status read without a same-cycle event empties the status
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == A_STAT) && !hit) |=> (status_q == '0));

endmodule

bind cosi_ctrl cosi_checker #(
  .W(W), .ADDR_W(ADDR_W), .CH_LO(CH_LO), .CH_HI(CH_HI)
) i_cosi_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wen_bit   (wdata[cosi_pkg::CTRL_EN_BIT]),
  .irq       (irq),
  .ctrl_en   (ctrl_en),
  .hit       (hit),
  .rise_hi_q (rise_hi_q),
  .fall_lo_q (fall_lo_q),
  .status_q  (status_q)
);

// File: tb/test_cosi_ctrl.sv
module test_cosi_ctrl;

  localparam logic [31:0] MASK   = 32'h000F_FFF0;
  localparam logic [4:0]  A_DATA = 5'h00;
  localparam logic [4:0]  A_RISE = 5'h04;
  localparam logic [4:0]  A_FALL = 5'h08;
  localparam logic [4:0]  A_STAT = 5'h0C;
  localparam logic [4:0]  A_CTRL = 5'h10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] din;
  logic        wr_en;
  logic        rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cosi_ctrl i_cosi_ctrl (
    .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic setin(input logic [31:0] v);
    @(negedge clk);
    din = v;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input logic [31:0] ctrl);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, ctrl);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic        live;
    rst = 1'b1; din = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    wt(3);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_DATA, v); chk("R1 data", v, 32'h0);
    rd(A_RISE, v); chk("R1 rise", v, 32'h0);
    rd(A_FALL, v); chk("R1 fall", v, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);

    // R4 control bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R4 ctrl readback", v, 32'h6);
    chk("R4 no irq with empty masks", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);

    // R3 mask storage
    wr(A_RISE, 32'hFFFF_FFFF);
    rd(A_RISE, v); chk("R3 rise mask", v, MASK);
    wr(A_FALL, 32'hA5A5_A5A5);
    rd(A_FALL, v); chk("R3 fall mask", v, 32'hA5A5_A5A5 & MASK);
    wr(A_RISE, 32'h0);
    wr(A_FALL, 32'h0);

    // R2 synchroniser latency
    setin(32'h1234_5678);
    rd(A_DATA, v); chk("R2 data still old", v, 32'h0);
    rd(A_DATA, v); chk("R2 data new", v, 32'h1234_5678);
    setin(32'h0); wt(4);

    // R11 disabled: no interrupt
    wr(A_RISE, 32'hFFFF_FFFF);
    setin(MASK); wt(4); chk("R11 disabled rise", {31'b0, irq}, 32'h0);
    setin(32'h0); wt(4); chk("R11 disabled fall", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h2);
    setin(MASK); wt(4); chk("R11 and-bit without enable", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);
    setin(32'h0); wt(4);

    // R5/R8 rising sweep over every channel
    wr(A_CTRL, 32'h4);
    for (int ch = 0; ch < 32; ch++) begin
      live = (ch >= 4) && (ch <= 19);
      setin(32'h1 << ch);
      wt(2); chk($sformatf("R5 latency ch%0d", ch), {31'b0, irq}, 32'h0);
      wt(2); chk($sformatf("R5 R8 rise ch%0d", ch), {31'b0, irq}, {31'b0, live});
      rd(A_STAT, v);
      chk($sformatf("R9 R8 rise status ch%0d", ch), v, live ? ((32'h1 << ch) & MASK) : 32'h0);
      if (ch == 4) begin
        rd(A_STAT, v); chk("R9 read clears", v, 32'h0);
      end
      ack(32'h4);
      setin(32'h0); wt(4);
      chk($sformatf("R5 fall ignored ch%0d", ch), {31'b0, irq}, 32'h0);
    end

    // R5/R8 falling sweep
    wr(A_CTRL, 32'h0);
    wr(A_RISE, 32'h0);
    wr(A_FALL, 32'hFFFF_FFFF);
    setin(32'hFFFF_FFFF); wt(4);
    wr(A_CTRL, 32'h4);
    for (int ch = 0; ch < 32; ch++) begin
      live = (ch >= 4) && (ch <= 19);
      setin(~(32'h1 << ch)); wt(4);
      chk($sformatf("R5 R8 fall ch%0d", ch), {31'b0, irq}, {31'b0, live});
      rd(A_STAT, v);
      chk($sformatf("R9 fall status ch%0d", ch), v, live ? (~(32'h1 << ch) & MASK) : 32'h0);
      ack(32'h4);
      setin(32'hFFFF_FFFF); wt(4);
      chk($sformatf("R5 rise ignored ch%0d", ch), {31'b0, irq}, 32'h0);
    end

    // R10 pending behaviour
    wr(A_CTRL, 32'h0);
    setin(32'h0); wt(4);
    wr(A_FALL, 32'h0);
    wr(A_RISE, 32'h30);
    wr(A_CTRL, 32'h4);
    setin(32'h10); wt(4); chk("R10 first event", {31'b0, irq}, 32'h1);
    setin(32'h30); wt(4); chk("R10 still pending", {31'b0, irq}, 32'h1);
    rd(A_STAT, v); chk("R10 capture refreshed", v, 32'h30);
    chk("R10 read keeps irq", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0); chk("R10 disable drops irq", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h4); chk("R10 re-enable quiet", {31'b0, irq}, 32'h0);
    setin(32'h0); wt(4); chk("R10 no fall mask", {31'b0, irq}, 32'h0);

    // R6/R7 level mode
    wr(A_CTRL, 32'h0);
    wr(A_RISE, 32'h30);
    wr(A_FALL, 32'h40);
    wr(A_CTRL, 32'h6);
    wt(4); chk("R6 none met", {31'b0, irq}, 32'h0);
    setin(32'h10); wt(4); chk("R6 partial 0x10", {31'b0, irq}, 32'h0);
    setin(32'h50); wt(4); chk("R6 partial 0x50", {31'b0, irq}, 32'h0);
    setin(32'h70); wt(4); chk("R6 low bit high", {31'b0, irq}, 32'h0);
    setin(32'h30); wt(4); chk("R6 all met", {31'b0, irq}, 32'h1);
    rd(A_STAT, v); chk("R6 status", v, 32'h30);
    ack(32'h6);
    wt(6); chk("R7 no refire after ack", {31'b0, irq}, 32'h0);
    setin(32'h130); wt(4); chk("R7 unselected change", {31'b0, irq}, 32'h0);
    setin(32'h120); wt(4); chk("R7 rearm no match", {31'b0, irq}, 32'h0);
    setin(32'h130); wt(4); chk("R7 refire after change", {31'b0, irq}, 32'h1);
    ack(32'h6);
    wt(4); chk("R7 disarmed again", {31'b0, irq}, 32'h0);
    wr(A_RISE, 32'h30);
    wt(2); chk("R7 mask write rearms", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    chk("R10 final disable", {31'b0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule